// File: doc/BRIEF.md
# Column-Serial AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key using the standard AES-128 forward cipher. A single-cycle `start_i` pulse captures the key and the plaintext. The core then computes the ciphertext over a fixed number of clock cycles and presents it on `ct_o` together with a single-cycle `done_o` pulse. No handshake or bus logic sits around the core. The surrounding logic supplies the operands, waits for `done_o`, and uses the result.

The datapath covers half of the state in each cycle: two of the four columns pass through SubBytes, ShiftRows, MixColumns and AddRoundKey together, so a round takes two cycles. ShiftRows is resolved by picking source bytes from all four columns of the state as it stood when the round began. The half-round results are therefore collected before the state is overwritten. The round key is not stored in expanded form. Each cycle derives only the two key words that the current column pair needs, from the previous round key held in place. The ten rounds take 20 cycles. They are preceded by a capture cycle and by two half-cycles of the initial key whitening, and followed by an output register stage. Accepted start to `done_o` is exactly 23 cycles.

Top module: `aes_col_core`

## Requirements
- R1: For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, `ct_o` is 69c4e0d86a7b0430d8cdb78070b4c55a. For key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, `ct_o` is 3925841d02dc09fbdc118597196a0b32. All 128-bit values use byte 0 in bits 127:120.
- R2: For any key and plaintext, `ct_o` at completion equals the AES-128 forward cipher of the captured operands.
- R3: `done_o` is high for exactly one cycle. It is high in the cycle that follows the 23rd rising edge after the edge that sampled an accepted `start_i`.
- R4: A `start_i` sampled while an operation is in progress has no effect, including on the edge that produces `done_o`. The running result and its timing are unchanged, and no further `done_o` follows.
- R5: `ct_o` changes only on the edge that raises `done_o`, and it holds its value until the next completion.
- R6: While `rst_ni` is low, and after reset until the first completion, `done_o` is 0 and `ct_o` is all zeros.
- R7: A `start_i` presented in the cycle in which `done_o` is high is accepted, so back-to-back operations start every 24 cycles.
- R8: `key_i` and `pt_i` are sampled only on the accepting edge. Changes on them during an operation do not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; ignored while busy |
| key_i | input | 128 | Cipher key, byte 0 in bits 127:120 |
| pt_i | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| ct_o | output | 128 | Ciphertext, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The ciphertext and `done_o` are due 23 rising edges after the edge that samples an accepted start. The core is otherwise idle, and no output moves except at that edge. The bench holds a behavioural model that counts the same edges from the start it sees accepted. On every falling edge it compares both outputs against the model, so any early, late, doubled or missing completion shows up in the first cycle it occurs. Directed sequences add to this. They place ignored starts in the middle of an operation and on its final edge, restart in the `done_o` cycle, and change the operand inputs while an operation runs. Each of these also carries explicit checks of the observed latency and result.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;
  localparam int BYTE_W       = 8;
  localparam int WORD_W       = 4 * BYTE_W;
  localparam int NB           = 4;
  localparam int BLK_W        = NB * WORD_W;
  localparam int COLS_PER_CYC = 2;
  localparam int HALVES       = NB / COLS_PER_CYC;
  localparam int HALF_W       = COLS_PER_CYC * WORD_W;
  localparam int NR           = 10;
  localparam int PRE_CYC      = 1 + HALVES;
  localparam int LATENCY      = PRE_CYC + NR * HALVES;
  localparam int STEP_W       = $clog2(LATENCY + 1);

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [WORD_W-1:0] mix_col(input logic [WORD_W-1:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_col_pkg::*;
(
  input  logic [BYTE_W-1:0] in_i,
  output logic [BYTE_W-1:0] out_o
);
  assign out_o = sub_byte(in_i);
endmodule

// File: rtl/aes_key_step.sv
// Derives two round-key words per cycle from the in-place key register.
// half 0: words 0,1 of the next round key; half 1: words 2,3 (word 1 already new).
module aes_key_step
  import aes_col_pkg::*;
(
  input  logic [BLK_W-1:0]  key_i,
  input  logic [7:0]        rcon_i,
  input  logic              half_i,
  output logic [HALF_W-1:0] words_o
);
  logic [WORD_W-1:0] k0, k1, k2, k3, rot, sub, n0, n1, n2, n3;

  assign {k0, k1, k2, k3} = key_i;
  assign rot = {k3[WORD_W-9:0], k3[WORD_W-1 -: 8]};

  for (genvar i = 0; i < 4; i++) begin : g_sb
    aes_sbox u_sb (
      .in_i  (rot[WORD_W-1-8*i -: 8]),
      .out_o (sub[WORD_W-1-8*i -: 8])
    );
  end

  assign n0 = k0 ^ sub ^ {rcon_i, 24'h0};
  assign n1 = n0 ^ k1;
  assign n2 = k1 ^ k2;
  assign n3 = n2 ^ k3;

  assign words_o = half_i ? {n2, n3} : {n0, n1};
endmodule

// File: rtl/aes_half_round.sv
// One round applied to the column pair selected by half_i.
module aes_half_round
  import aes_col_pkg::*;
(
  input  logic [BLK_W-1:0]  state_i,
  input  logic [HALF_W-1:0] rk_i,
  input  logic              half_i,
  input  logic              last_i,
  output logic [HALF_W-1:0] cols_o
);
  logic [7:0] by_w [16];

  for (genvar i = 0; i < 16; i++) begin : g_by
    assign by_w[i] = state_i[BLK_W-1-8*i -: 8];
  end

  for (genvar k = 0; k < COLS_PER_CYC; k++) begin : g_col
    logic [WORD_W-1:0] sub_col, mixed;
    for (genvar r = 0; r < 4; r++) begin : g_row
      logic [1:0] src_col;
      // row r of output column c comes from column (c + r) mod 4
      assign src_col = {half_i, 1'b0} + 2'(k + r);
      aes_sbox u_sb (
        .in_i  (by_w[{src_col, 2'(r)}]),
        .out_o (sub_col[WORD_W-1-8*r -: 8])
      );
    end
    assign mixed = last_i ? sub_col : mix_col(sub_col);
    assign cols_o[HALF_W-1-WORD_W*k -: WORD_W] = mixed ^ rk_i[HALF_W-1-WORD_W*k -: WORD_W];
  end
endmodule

// File: rtl/aes_col_core.sv
module aes_col_core
  import aes_col_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic [BLK_W-1:0] pt_i,
  output logic [BLK_W-1:0] ct_o,
  output logic             done_o
);
  localparam logic [STEP_W-1:0] STEP_FIRST   = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_RND0    = STEP_W'(PRE_CYC);
  localparam logic [STEP_W-1:0] STEP_LASTRND = STEP_W'(LATENCY - HALVES);
  localparam logic [STEP_W-1:0] STEP_OUT     = STEP_W'(LATENCY);

  logic [BLK_W-1:0]  st_q, key_q;
  logic [HALF_W-1:0] lo_q;
  logic [7:0]        rcon_q;
  logic              busy_q;
  logic [STEP_W-1:0] step_q;

  logic              half, in_ark, last_rnd;
  logic [HALF_W-1:0] rk_words, rnd_cols;

  // step 1,2: whitening halves; 3..22: round halves; 23: output
  assign half     = ~step_q[0];
  assign in_ark   = step_q < STEP_RND0;
  assign last_rnd = step_q >= STEP_LASTRND;

  aes_key_step u_key (
    .key_i   (key_q),
    .rcon_i  (rcon_q),
    .half_i  (half),
    .words_o (rk_words)
  );

  aes_half_round u_rnd (
    .state_i (st_q),
    .rk_i    (rk_words),
    .half_i  (half),
    .last_i  (last_rnd),
    .cols_o  (rnd_cols)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      key_q  <= '0;
      lo_q   <= '0;
      rcon_q <= 8'h01;
      busy_q <= 1'b0;
      step_q <= '0;
      ct_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          st_q   <= pt_i;
          key_q  <= key_i;
          rcon_q <= 8'h01;
          busy_q <= 1'b1;
          step_q <= STEP_FIRST;
        end
      end else if (step_q == STEP_OUT) begin
        ct_o   <= st_q;
        done_o <= 1'b1;
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
        if (in_ark) begin
          if (!half) st_q[BLK_W-1 -: HALF_W] <= st_q[BLK_W-1 -: HALF_W] ^ key_q[BLK_W-1 -: HALF_W];
          else       st_q[HALF_W-1:0]        <= st_q[HALF_W-1:0] ^ key_q[HALF_W-1:0];
        end else if (!half) begin
          lo_q                      <= rnd_cols;
          key_q[BLK_W-1 -: HALF_W]  <= rk_words;
        end else begin
          st_q              <= {lo_q, rnd_cols};
          key_q[HALF_W-1:0] <= rk_words;
          rcon_q            <= xtime(rcon_q);
        end
      end
    end
  end

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_q) && $past(step_q) == STEP_OUT));

  p_busy_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_q != STEP_OUT) |=> (busy_q && step_q == $past(step_q) + 1'b1));

  p_ct_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ct_o));

  p_accept_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (busy_q && step_q == STEP_FIRST));
endmodule

// File: tb/aes_col_core_tb.sv
module aes_col_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key = '0;
  logic [127:0] pt = '0;
  logic [127:0] ct;
  logic         done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int run_cyc = 0;

  logic [7:0] sb [256];

  always #5 clk = ~clk;

  aes_col_core u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .key_i   (key),
    .pt_i    (pt),
    .ct_o    (ct),
    .done_o  (done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%032h expected=%032h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] g2(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] w [176];
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] tmp [4];
    logic [7:0] rc, x;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) w[i] = k[127-8*i -: 8];
    for (int i = 16; i < 176; i += 4) begin
      for (int j = 0; j < 4; j++) tmp[j] = w[i-4+j];
      if (i % 16 == 0) begin
        x = tmp[0];
        tmp[0] = sb[tmp[1]] ^ rc; tmp[1] = sb[tmp[2]]; tmp[2] = sb[tmp[3]]; tmp[3] = sb[x];
        rc = g2(rc);
      end
      for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ tmp[j];
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i];
    for (int r = 1; r <= 10; r++) begin
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) t[4*c+q] = sb[s[4*((c+q)%4)+q]];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[4*c+0] = g2(t[4*c]) ^ g2(t[4*c+1]) ^ t[4*c+1] ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ g2(t[4*c+1]) ^ g2(t[4*c+2]) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ g2(t[4*c+2]) ^ g2(t[4*c+3]) ^ t[4*c+3];
          s[4*c+3] = g2(t[4*c]) ^ t[4*c] ^ t[4*c+1] ^ t[4*c+2] ^ g2(t[4*c+3]);
        end else begin
          for (int q = 0; q < 4; q++) s[4*c+q] = t[4*c+q];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[16*r+i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // behavioural cycle model of the ports
  bit           m_busy = 1'b0;
  bit           m_done = 1'b0;
  int           m_cnt = 0;
  logic [127:0] m_ct = '0;
  logic [127:0] m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_ct = '0; run_cyc = 0;
    end else begin
      run_cyc++;
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 23) begin
          m_busy = 1'b0; m_done = 1'b1; m_ct = m_pend;
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 0; m_pend = ref_enc(key, pt);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cyc > 0) begin
      check(done === m_done, "R3 done timing", {127'h0, done}, {127'h0, m_done});
      check(ct === m_ct, "R2/R5 ciphertext", ct, m_ct);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_op(input logic [127:0] k, input logic [127:0] p, input bit scramble,
                        output int lat);
    @(negedge clk);
    start = 1'b1; key = k; pt = p;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      if (scramble) begin key = rnd128(); pt = rnd128(); end
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    logic [7:0] p8, q8;
    int lat;
    int extra;
    logic [127:0] ka, pa, exp_a;
    p8 = 8'h01; q8 = 8'h01;
    do begin
      p8 = p8 ^ {p8[6:0], 1'b0} ^ (p8[7] ? 8'h1b : 8'h00);
      q8 = q8 ^ {q8[6:0], 1'b0};
      q8 = q8 ^ {q8[5:0], 2'b0};
      q8 = q8 ^ {q8[3:0], 4'b0};
      if (q8[7]) q8 = q8 ^ 8'h09;
      sb[p8] = q8 ^ {q8[6:0], q8[7]} ^ {q8[5:0], q8[7:6]} ^ {q8[4:0], q8[7:5]}
             ^ {q8[3:0], q8[7:4]} ^ 8'h63;
    end while (p8 != 8'h01);
    sb[0] = 8'h63;

    // R6: reset state
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R6 done in reset", {127'h0, done}, '0);
    check(ct === '0, "R6 ct in reset", ct, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done === 1'b0 && ct === '0, "R6 idle after reset", ct, '0);

    // R1: known answers, with R3 latency
    run_op(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 1'b0, lat);
    check(ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 vector A", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check(lat == 24, "R3 latency (23 periods after sampling edge)", 128'(lat), 128'd24);
    run_op(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734, 1'b0, lat);
    check(ct === 128'h3925841d02dc09fbdc118597196a0b32, "R1 vector B", ct, 128'h3925841d02dc09fbdc118597196a0b32);
    @(negedge clk);
    check(done === 1'b0, "R3 single-cycle done", {127'h0, done}, '0);

    // R8: inputs change while running
    ka = rnd128(); pa = rnd128();
    run_op(ka, pa, 1'b1, lat);
    check(ct === ref_enc(ka, pa), "R8 operands captured at start", ct, ref_enc(ka, pa));

    // R4: starts mid-run and on the completing edge are ignored
    ka = rnd128(); pa = rnd128(); exp_a = ref_enc(ka, pa);
    @(negedge clk);
    start = 1'b1; key = ka; pt = pa;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (k == 1)  start = 1'b0;
      if (k == 10) begin start = 1'b1; key = rnd128(); pt = rnd128(); end
      if (k == 11) start = 1'b0;
      if (k == 23) begin start = 1'b1; key = rnd128(); end
      if (k == 24) start = 1'b0;
    end
    check(done === 1'b1, "R4 done timing kept", {127'h0, done}, 128'd1);
    check(ct === exp_a, "R4 result kept", ct, exp_a);
    extra = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R4 no done from ignored start", 128'(extra), '0);
    check(ct === exp_a, "R5 ct held while idle", ct, exp_a);

    // R7: restart in the done cycle
    run_op(rnd128(), rnd128(), 1'b0, lat);
    ka = rnd128(); pa = rnd128();
    start = 1'b1; key = ka; pt = pa;
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    check(lat == 24, "R7 back-to-back latency", 128'(lat), 128'd24);
    check(ct === ref_enc(ka, pa), "R7 back-to-back result", ct, ref_enc(ka, pa));

    // R2: random vectors
    for (int v = 0; v < 16; v++) begin
      ka = rnd128(); pa = rnd128();
      run_op(ka, pa, v[0], lat);
      check(ct === ref_enc(ka, pa), "R2 random vector", ct, ref_enc(ka, pa));
      check(lat == 24, "R3 latency random", 128'(lat), 128'd24);
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule